// File: doc/BRIEF.md
# Serial Receive Path with Status Byte

This block turns an asynchronous serial line into bytes that a processor can read. A 16x oversampling tick, produced elsewhere, paces a small receive state machine. The machine finds a start bit, samples each bit at its centre, and hands each finished character to a holding register. From there the character moves into a two-entry receive queue. The processor pops bytes from the head of the queue. It reads an 8-bit status byte and clears error flags by writing ones. Dropping the receive-enable input clears every error flag and parks the receiver.

The receive state machine has five states. IDLE waits for a low level on the synchronised line. START counts to the middle of the start bit: a high sample there goes back to IDLE (false start), and a low sample goes on to DATA. DATA takes eight bits, LSB first. After the last bit it goes to PAR when parity is on, or to STOP when it is off. PAR takes one parity bit and goes to STOP. STOP samples the stop bit, emits the character and returns to IDLE. Any state drops to IDLE while receive is disabled.

The holding register acts as a third slot. Overrun is raised only when both queue entries and the holding register are all occupied. Parity is judged when a character leaves the holding register for the queue. Framing is judged when the stop bit is sampled.

Top module: `uart_rx_stat`

## Requirements
- R1: The status byte reads, bit 7 down to bit 0: constant 0, framing error, parity error, overrun, two bytes queued, transmit busy input, byte ready, transmit buffer empty input. After reset it equals {0,0,0,0,0,tx_busy_i,0,tx_empty_i}.
- R2: A frame is a low start bit, 8 data bits LSB first, an optional parity bit, then one stop bit. Each bit lasts 16 ticks and is sampled at its centre. A received byte appears on rd_data once it has been queued.
- R3: A low pulse that is high again at the centre of the start bit is discarded, and no byte is queued.
- R4: A frame whose stop bit samples 0 sets the framing error flag (bit 6). The byte is still queued.
- R5: With par_en=1, the expected parity bit is the XOR of the data bits XOR par_odd (par_odd=0 even, 1 odd). A mismatch sets the parity error flag (bit 5) when the byte enters the queue. With par_en=0 no parity bit is expected and the flag never sets.
- R6: Byte ready (bit 1) is 1 while the queue holds at least one byte. A one-cycle rd_pop removes the oldest byte, and bytes come out in arrival order.
- R7: Bit 3 is 1 while the queue holds two bytes. It drops on the pop of the first byte. A byte waiting in the holding register then refills the queue within a few clocks.
- R8: When the queue is full and the holding register is occupied, a new frame replaces the holding register and sets overrun (bit 4). The queued bytes are left unchanged.
- R9: A status write with 1 in bit 6, 5 or 4 clears that flag. A 0 in those bits, or any value in bits 3..0, changes nothing. An error event in the same cycle as its clear wins.
- R10: While rx_en is 0, bits 6..4 read 0 from the next clock. The queued bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; 0 parks the receiver and clears errors |
| os_tick | input | 1 | 16x bit-rate oversampling strobe |
| rxd | input | 1 | Serial receive line, idle high |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_busy_i | input | 1 | Transmit shifter busy, shown in status bit 2 |
| tx_empty_i | input | 1 | Transmit buffer empty, shown in status bit 0 |
| rd_pop | input | 1 | Pop the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data (ones in bits 6..4 clear flags) |
| stat_rdata | output | 8 | Status byte |

## Verification
A receive machine that drifts from bit centres shows as wrong bytes on rd_data about one frame later. A false start that is accepted shows as a phantom ready flag one frame later. A queue level that is off by one shows in bits 1 and 3 of the status byte on the very clock after a pop or a refill, and as out-of-order data on the next read. Error flags that are wrongly held or cleared appear in the status byte one clock after the write, the enable change or the offending frame. The overrun case is staged with four back-to-back frames and then drained, so a queue entry wrongly overwritten shows up as a wrong byte on the drain.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam int unsigned STAT_FER = 6;
    localparam int unsigned STAT_PER = 5;
    localparam int unsigned STAT_OER = 4;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_pbit,
    output logic              frm_stop
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [IW-1:0] TOPB = IW'(DATA_W - 1);

    rx_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [1:0] sync_q;
    logic rxs;
    logic at_end;

    assign rxs    = sync_q[1];
    assign at_end = tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!rxs) state_d = RX_START;
            RX_START: if (tick && cnt_q == MID) state_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (at_end && idx_q == TOPB) state_d = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (at_end) state_d = RX_STOP;
            RX_STOP:  if (at_end) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            frm_valid <= 1'b0;
            frm_pbit  <= 1'b0;
            frm_stop  <= 1'b1;
        end else begin
            frm_valid <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else begin
                unique case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        idx_q <= '0;
                    end
                    RX_START: if (tick) cnt_q <= (cnt_q == MID) ? '0 : cnt_q + 1'b1;
                    RX_DATA: if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rxs, sh_q[DATA_W-1:1]};
                            idx_q <= (idx_q == TOPB) ? '0 : idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PAR: if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q    <= '0;
                            frm_pbit <= rxs;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            frm_stop  <= rxs;
                            frm_valid <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign frm_data = sh_q;

    // R2
    frm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    // R3
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == RX_START && tick && cnt_q == MID && rxs) |=> (state_q == RX_IDLE));

    // R2
    bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RX_DATA) |=> (state_q != RX_DATA || idx_q == '0));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_pbit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              par_err,
    output logic              ovr
);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] hold_data_q;
    logic hold_pbit_q, hold_v_q;
    logic [LW-1:0] level_q, wr_pos;
    logic do_pop, move;

    assign do_pop = pop && (level_q != '0);
    assign move   = hold_v_q && (level_q < FULL);
    assign wr_pos = level_q - LW'(do_pop);

    always_ff @(posedge clk) begin
        if (do_pop) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) mem_q[i] <= mem_q[i+1];
        end
        if (move) mem_q[wr_pos[AW-1:0]] <= hold_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q     <= '0;
            hold_v_q    <= 1'b0;
            hold_data_q <= '0;
            hold_pbit_q <= 1'b0;
            par_err     <= 1'b0;
            ovr         <= 1'b0;
        end else begin
            level_q <= level_q - LW'(do_pop) + LW'(move);
            par_err <= move && par_en && (hold_pbit_q != ((^hold_data_q) ^ par_odd));
            ovr     <= in_valid && hold_v_q && !move;
            if (in_valid) begin
                hold_data_q <= in_data;
                hold_pbit_q <= in_pbit;
                hold_v_q    <= 1'b1;
            end else if (move) begin
                hold_v_q <= 1'b0;
            end
        end
    end

    assign head_data = (level_q != '0) ? mem_q[0] : '0;
    assign level     = level_q;

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL);

    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hold_v_q && level_q == FULL && !pop) |=> (ovr && level_q == FULL && hold_v_q));

    // R6
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level_q != '0 && !hold_v_q) |=> (level_q == $past(level_q) - 1'b1));
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_busy_i,
    input  logic              tx_empty_i,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    output logic [7:0]        stat_rdata
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic frm_valid, frm_pbit, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic [LW-1:0] level;
    logic par_err, ovr;
    logic fer_q, per_q, oer_q;
    logic fer_set, clr_fer, clr_per, clr_oer;
    logic unused_wbits;

    uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rxd(rxd),
        .par_en(par_en), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_pbit(frm_pbit), .frm_stop(frm_stop)
    );

    uart_rx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .in_valid(frm_valid), .in_data(frm_data),
        .in_pbit(frm_pbit), .par_en(par_en), .par_odd(par_odd), .pop(rd_pop),
        .head_data(rd_data), .level(level), .par_err(par_err), .ovr(ovr)
    );

    assign fer_set = frm_valid && !frm_stop;
    assign clr_fer = stat_wr && stat_wdata[STAT_FER];
    assign clr_per = stat_wr && stat_wdata[STAT_PER];
    assign clr_oer = stat_wr && stat_wdata[STAT_OER];
    assign unused_wbits = ^{stat_wdata[7], stat_wdata[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fer_q <= 1'b0;
            per_q <= 1'b0;
            oer_q <= 1'b0;
        end else if (!rx_en) begin
            fer_q <= 1'b0;
            per_q <= 1'b0;
            oer_q <= 1'b0;
        end else begin
            fer_q <= fer_set || (fer_q && !clr_fer);
            per_q <= par_err || (per_q && !clr_per);
            oer_q <= ovr     || (oer_q && !clr_oer);
        end
    end

    assign stat_rdata = {1'b0, fer_q, per_q, oer_q,
                         level == LW'(DEPTH), tx_busy_i, level != '0, tx_empty_i};

    // R10
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (stat_rdata[6:4] == 3'b000));

    // R9
    w1c_oer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && clr_oer && !ovr) |=> !oer_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && fer_set) |=> fer_q);

    // R7
    two_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[3] |-> stat_rdata[1]);
endmodule

// File: tb/uart_rx_stat_tb.sv
`timescale 1ns/1ps
module uart_rx_stat_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b1, os_tick = 1'b0, rxd = 1'b1;
    logic par_en = 1'b0, par_odd = 1'b0;
    logic tx_busy_i = 1'b0, tx_empty_i = 1'b1;
    logic rd_pop = 1'b0, stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic [7:0] rd_data, stat_rdata;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_rx_stat u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .tx_busy_i(tx_busy_i),
        .tx_empty_i(tx_empty_i), .rd_pop(rd_pop), .rd_data(rd_data),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
    );

    // fields: [13:6] data, [5] parity on, [4] odd, [3] corrupt parity, [2] stop, [1] exp per, [0] exp fer
    localparam logic [13:0] VEC [7] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            os_tick = (t == 3);
            t = (t + 1) % 4;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic pon, input logic pb, input logic stp);
        rxd = 1'b0; clocks(64);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; clocks(64); end
        if (pon) begin rxd = pb; clocks(64); end
        rxd = stp; clocks(48);
        rxd = 1'b1; clocks(120);
    endtask

    task automatic pop1();
        rd_pop = 1'b1; clocks(1); rd_pop = 1'b0; clocks(3);
    endtask

    task automatic wstat(input logic [7:0] v);
        stat_wr = 1'b1; stat_wdata = v; clocks(1); stat_wr = 1'b0; stat_wdata = '0; clocks(1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clocks(5);
        rst_n = 1'b1;
        clocks(2);
        // R1 reset value
        check("R1 reset status", stat_rdata, 8'h01);
        check("R6 empty data", rd_data, 8'h00);
        tx_busy_i = 1'b1; tx_empty_i = 1'b0; clocks(1);
        check("R1 tx inputs", stat_rdata, 8'h04);
        tx_busy_i = 1'b0; tx_empty_i = 1'b1; clocks(1);

        // R2 R4 R5 R9 table walk
        for (int k = 0; k < 7; k++) begin
            logic [13:0] v;
            logic pb;
            v = VEC[k];
            par_en = v[5]; par_odd = v[4];
            pb = (^v[13:6]) ^ v[4] ^ v[3];
            send(v[13:6], v[5], pb, v[2]);
            check("R2 R4 R5 status", stat_rdata, {1'b0, v[0], v[1], 5'b00011});
            check("R2 data", rd_data, v[13:6]);
            pop1();
            wstat(8'h70);
            check("R9 cleared", stat_rdata, 8'h01);
        end
        par_en = 1'b0; par_odd = 1'b0;

        // R3 false start
        rxd = 1'b0; clocks(12); rxd = 1'b1; clocks(900);
        check("R3 no byte", stat_rdata, 8'h01);

        // R7 two bytes
        send(8'h12, 1'b0, 1'b0, 1'b1);
        send(8'h34, 1'b0, 1'b0, 1'b1);
        check("R7 two queued", stat_rdata, 8'h0B);
        check("R6 order first", rd_data, 8'h12);
        pop1();
        check("R7 after pop", stat_rdata, 8'h03);
        check("R6 order second", rd_data, 8'h34);
        pop1();
        check("R6 empty", stat_rdata, 8'h01);

        // R8 overrun
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        send(8'h33, 1'b0, 1'b0, 1'b1);
        send(8'h44, 1'b0, 1'b0, 1'b1);
        check("R8 overrun flag", stat_rdata, 8'h1B);
        check("R8 head kept", rd_data, 8'h11);
        pop1();
        check("R7 refill", stat_rdata, 8'h1B);
        check("R8 second kept", rd_data, 8'h22);
        pop1();
        check("R8 newest held", rd_data, 8'h44);
        check("R8 one left", stat_rdata, 8'h13);
        wstat(8'h00);
        check("R9 write zero", stat_rdata, 8'h13);
        wstat(8'h0F);
        check("R9 low bits ignored", stat_rdata, 8'h13);
        wstat(8'h10);
        check("R9 clear overrun", stat_rdata, 8'h03);
        pop1();
        check("R6 drained", stat_rdata, 8'h01);

        // R10 enable clears errors
        send(8'h77, 1'b0, 1'b0, 1'b0);
        check("R4 framing", stat_rdata, 8'h43);
        rx_en = 1'b0; clocks(2);
        check("R10 disabled clears", stat_rdata, 8'h03);
        rx_en = 1'b1; clocks(2);
        check("R10 byte kept", rd_data, 8'h77);
        pop1();
        check("R10 final", stat_rdata, 8'h01);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule